// File: doc/BRIEF.md
# Exact Four-Bank Recency Tracker

This block keeps the exact least-recently-used order among a set of banks (four by default) by storing a single order bit for each unordered pair of banks. Each bit records which bank of its pair was referenced more recently. A reference strobe with a bank index makes that bank the newest in every pair that contains it. The block decodes the oldest bank straight from the stored bits, so a cache replacement controller can read the victim index in the same cycle.

The raw pair bits are also brought out. An integrity flag rises whenever those bits do not describe a consistent total order. With four banks, only 24 of the 64 possible patterns are consistent: one per ordering of the banks. Reset is synchronous and puts the banks in ascending age order, with bank 0 the oldest.

Top module: `recency_matrix_lru`

## Requirements
- R1: The pair bit for banks i<j sits at index j*(j-1)/2+i and is 1 when bank j is more recent than bank i. With four banks: bit0 (1 over 0), bit1 (2 over 0), bit2 (2 over 1), bit3 (3 over 0), bit4 (3 over 1), bit5 (3 over 2).
- R2: A cycle with `rst` high loads all pair bits to 1 (order 0,1,2,3 from oldest to newest), so `lru_bank` reads 0 after reset.
- R3: When `ref_en` is high at a clock edge, every bit in which `ref_bank` is the newer member becomes 1 and every bit in which it is the older member becomes 0. All other bits keep their values, and the new bits appear after that edge.
- R4: When `ref_en` is low at a clock edge, `order_bits` does not change.
- R5: `lru_bank` is combinational from the state and names the bank that every other bank is recorded as more recent than.
- R6: A reference to the bank that is already the newest leaves `order_bits` unchanged.
- R7: `order_illegal` is high exactly when the state is not one of the 24 consistent orderings. It stays low for any sequence of references after reset.
- R8: After a reference, the referenced bank is newer than every other bank.
- R9: After references to four distinct banks, `lru_bank` equals the first of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_en | input | 1 | Reference strobe |
| ref_bank | input | 2 | Index of the referenced bank |
| lru_bank | output | 2 | Index of the oldest bank |
| order_bits | output | 6 | Stored pair-order bits |
| order_illegal | output | 1 | High when the state is not a consistent ordering |

## Verification
On every cycle, the assertions check four things: that reset loads the all-ones pattern, that the state holds when idle or when the newest bank is referenced again, that a referenced bank becomes the newest, and that the state stays consistent so the oldest and newest banks never coincide. Only the bench scenarios can show the exact bit values after arbitrary reference streams. They also show that the oldest bank is the first of a distinct four-bank sequence. These are compared each clock against a queue-based ordering model.

// File: rtl/recency_pkg.sv
package recency_pkg;
   // Position of the order bit for the pair (lo, hi), lo < hi.
   function automatic int pair_idx(input int lo, input int hi);
      return (hi * (hi - 1)) / 2 + lo;
   endfunction

   function automatic int pair_count(input int ways);
      return (ways * (ways - 1)) / 2;
   endfunction
endpackage

// File: rtl/recency_update.sv
module recency_update
   import recency_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   localparam int IDX_W   = $clog2(NUM_WAYS),
   localparam int PAIRS   = pair_count(NUM_WAYS)
) (
   input  logic             ref_en,
   input  logic [IDX_W-1:0] ref_bank,
   input  logic [PAIRS-1:0] cur_bits,
   output logic [PAIRS-1:0] nxt_bits
);
   logic ref_ok;

   // Variant: index range guard only when the index space is not full.
   if ((1 << IDX_W) != NUM_WAYS) begin : g_guard
      assign ref_ok = ref_en && (int'(ref_bank) < NUM_WAYS);
   end else begin : g_noguard
      assign ref_ok = ref_en;
   end

   for (genvar hi = 1; hi < NUM_WAYS; hi++) begin : g_hi
      for (genvar lo = 0; lo < hi; lo++) begin : g_lo
         localparam int K = pair_idx(lo, hi);
         logic hit_hi, hit_lo;
         assign hit_hi = ref_ok && (ref_bank == IDX_W'(hi));
         assign hit_lo = ref_ok && (ref_bank == IDX_W'(lo));
         assign nxt_bits[K] = hit_hi ? 1'b1 : (hit_lo ? 1'b0 : cur_bits[K]);
      end
   end
endmodule

// File: rtl/recency_decode.sv
module recency_decode
   import recency_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   localparam int IDX_W   = $clog2(NUM_WAYS),
   localparam int PAIRS   = pair_count(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PAIRS-1:0] bits,
   output logic [IDX_W-1:0] oldest,
   output logic [IDX_W-1:0] newest,
   output logic             bad
);
   logic [IDX_W-1:0]    wins [NUM_WAYS];
   logic [NUM_WAYS-1:0] rank_seen;

   // Number of banks each bank is recorded as newer than.
   always_comb begin
      for (int b = 0; b < NUM_WAYS; b++) wins[b] = '0;
      for (int hi = 1; hi < NUM_WAYS; hi++) begin
         for (int lo = 0; lo < hi; lo++) begin
            if (bits[pair_idx(lo, hi)]) wins[hi] = wins[hi] + IDX_W'(1);
            else                        wins[lo] = wins[lo] + IDX_W'(1);
         end
      end
   end

   // A consistent order gives every bank a distinct rank.
   always_comb begin
      rank_seen = '0;
      for (int b = 0; b < NUM_WAYS; b++) rank_seen[wins[b]] = 1'b1;
   end
   assign bad = ~&rank_seen;

   always_comb begin
      oldest = '0;
      newest = '0;
      for (int b = NUM_WAYS - 1; b >= 0; b--) begin
         if (wins[b] == '0) oldest = IDX_W'(b);
         if (wins[b] == IDX_W'(NUM_WAYS - 1)) newest = IDX_W'(b);
      end
   end

   // R5: in a consistent order the oldest and newest banks differ.
   p_oldest_not_newest_r5: assert property (@(posedge clk) disable iff (rst)
      !bad |-> (oldest != newest));
endmodule

// File: rtl/recency_matrix_lru.sv
module recency_matrix_lru
   import recency_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   localparam int IDX_W   = $clog2(NUM_WAYS),
   localparam int PAIRS   = pair_count(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_en,
   input  logic [IDX_W-1:0] ref_bank,
   output logic [IDX_W-1:0] lru_bank,
   output logic [PAIRS-1:0] order_bits,
   output logic             order_illegal
);
   if (NUM_WAYS < 2 || NUM_WAYS > 16) begin : g_bad_ways
      $error("recency_matrix_lru: NUM_WAYS must lie in 2..16");
   end

   logic [PAIRS-1:0] state_q, state_d;
   logic [IDX_W-1:0] mru_bank;

   recency_update #(.NUM_WAYS(NUM_WAYS)) u_update (
      .ref_en   (ref_en),
      .ref_bank (ref_bank),
      .cur_bits (state_q),
      .nxt_bits (state_d)
   );

   always_ff @(posedge clk) begin
      if (rst) state_q <= '1;
      else     state_q <= state_d;
   end

   recency_decode #(.NUM_WAYS(NUM_WAYS)) u_decode (
      .clk    (clk),
      .rst    (rst),
      .bits   (state_q),
      .oldest (lru_bank),
      .newest (mru_bank),
      .bad    (order_illegal)
   );

   assign order_bits = state_q;

   p_reset_ones_r2: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (&order_bits));
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !ref_en |=> $stable(order_bits));
   p_mru_reref_r6: assert property (@(posedge clk) disable iff (rst)
      (ref_en && ref_bank == mru_bank) |=> $stable(order_bits));
   p_ref_is_newest_r8: assert property (@(posedge clk) disable iff (rst)
      (ref_en && int'(ref_bank) < NUM_WAYS) |=> (mru_bank == $past(ref_bank)));
   p_always_legal_r7: assert property (@(posedge clk) disable iff (rst)
      !order_illegal);
endmodule

// File: tb/recency_matrix_lru_bench.sv
module recency_matrix_lru_bench;
   logic       clk = 1'b0;
   logic       rst;
   logic       ref_en;
   logic [1:0] ref_bank;
   logic [1:0] lru_bank;
   logic [5:0] order_bits;
   logic       order_illegal;

   int checks = 0;
   int failures = 0;
   int age_q[$];       // model: front = oldest, back = newest
   logic [5:0] prev_bits;

   always #5 clk = ~clk;

   recency_matrix_lru u_recency_matrix_lru (
      .clk(clk), .rst(rst), .ref_en(ref_en), .ref_bank(ref_bank),
      .lru_bank(lru_bank), .order_bits(order_bits), .order_illegal(order_illegal)
   );

   function automatic int pos_of(int b);
      foreach (age_q[p]) if (age_q[p] == b) return p;
      return -1;
   endfunction

   // R1 encoding built from the model order.
   function automatic logic [5:0] model_bits();
      logic [5:0] v;
      int k;
      v = '0;
      k = 0;
      for (int hi = 1; hi < 4; hi++)
         for (int lo = 0; lo < hi; lo++) begin
            v[k] = pos_of(hi) > pos_of(lo);
            k++;
         end
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check(order_bits == model_bits(), {tag, " R1 R3 bits"}, order_bits, model_bits());
      check(lru_bank == 2'(age_q[0]), "R5 lru", lru_bank, age_q[0]);
      check(order_illegal == 1'b0, "R7 illegal", order_illegal, 0);
   endtask

   task automatic step(input bit en, input int bank);
      ref_en = en;
      ref_bank = 2'(bank);
      prev_bits = order_bits;
      @(posedge clk);
      #1;
      if (en) begin
         age_q.delete(pos_of(bank));
         age_q.push_back(bank);
      end
      @(negedge clk);
      ref_en = 1'b0;
      compare_all(en ? "ref" : "idle");
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst = 1'b1;
      ref_en = 1'b0;
      ref_bank = '0;
      age_q = '{0, 1, 2, 3};
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(order_bits == 6'h3f, "R2 reset bits", order_bits, 6'h3f);
      check(lru_bank == 2'd0, "R2 reset lru", lru_bank, 0);
      rst = 1'b0;

      // R6: re-reference current newest bank 3
      step(1, 3);
      check(order_bits == prev_bits, "R6 mru reref", order_bits, prev_bits);

      // R4: idle cycles hold
      step(0, 1);
      check(order_bits == prev_bits, "R4 idle hold", order_bits, prev_bits);
      step(0, 2);

      // R3 single reference to bank 0: bits 0,1,3 cleared
      step(1, 0);
      check(order_bits == 6'b110100, "R3 ref0", order_bits, 6'b110100);
      check(lru_bank == 2'd1, "R5 lru after ref0", lru_bank, 1);

      // R9: distinct sequence 2,0,3,1 -> oldest is 2
      step(1, 2); step(1, 0); step(1, 3); step(1, 1);
      check(lru_bank == 2'd2, "R9 first of four", lru_bank, 2);

      // R8: repeated references to one bank keep it newest
      step(1, 1);
      check(order_bits == prev_bits, "R6 repeat", order_bits, prev_bits);

      // Random stream compared against the model every clock
      for (int n = 0; n < 400; n++) begin
         step($urandom_range(0, 3) != 0, int'($urandom_range(0, 3)));
      end

      // R2: reset mid-run restores the initial order
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      age_q = '{0, 1, 2, 3};
      check(order_bits == 6'h3f, "R2 reset again", order_bits, 6'h3f);
      compare_all("post-reset");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule